// File: doc/BRIEF.md
# Conveyor Sort and Orientation Sequencer

This block sequences the actuators of a camera-based sorting station on a conveyor. A part that arrives at the entry sensor triggers a one-cycle image-capture strobe. The block then waits for a verdict from an external classifier, which gives a two-bit class code and a signed tilt angle. It diverts the part by its class, rights it, or stops the line. Diverted parts go to a side conveyor through a first pusher. A defective part is ejected from that conveyor by a second pusher once the second sensor sees it. A good part that is tilted moderately is turned by an orientation device. That device stays on until a pressure comparison reports contact, and a watchdog guards it.

Every delay, pusher pulse width, angle limit and the orientation watchdog limit is an input. The block handles one part at a time. All delays and the watchdog share one down-counter, so only one time window is open at any moment. A fault holds the line stopped until an explicit clear arrives.

Top module: `sort_station_ctrl`

## Requirements
- R1: In the idle state, a rising edge on `entry_seen` makes `acq_strobe` high for exactly one cycle, in the cycle right after the edge that samples the rise. Rises of `entry_seen` while a part is being handled produce no strobe.
- R2: The class codes are 0 for good, 1 for plain second grade, 2 for defective and 3 for unknown. Codes 1, 2 and 3 divert the part, whatever its angle. `push1` rises `dly_push1` clock edges after the edge that accepts `cls_valid`, and a delay of 0 acts as 1.
- R3: Each pusher pulse lasts `pulse_len` cycles, and a value of 0 acts as 1.
- R4: A `push2` pulse happens only for code 2. After the `push1` pulse ends, the first rise of `divert_seen` starts a `dly_push2` delay, counted from the edge that samples that rise. Codes 1 and 3 return to idle, and a later `divert_seen` does nothing.
- R5: A good part whose angle magnitude is strictly below `ang_lo` drives no actuator, and the block is idle again on the next edge.
- R6: A good part whose angle magnitude is strictly above `ang_hi` raises `err_stop` on the edge that accepts the verdict. This test takes priority over the pass test. A magnitude equal to `ang_hi` is corrected rather than rejected.
- R7: Any other good part raises `orient_on` `dly_orient` edges after acceptance (0 acts as 1). `orient_on` stays high until an edge samples `press_ok` high, and it falls on that edge. It is high for at least one cycle even when `press_ok` is already high.
- R8: If `press_ok` is not sampled high within `orient_limit` cycles of `orient_on`, then `orient_on` falls and `err_stop` rises on the same edge. A press sampled on the last allowed edge counts as success.
- R9: `err_stop` stays high until `err_clr` is sampled high, and then falls on that edge. While it is high, all actuators and the strobe stay low and `entry_seen` is ignored.
- R10: At most one of `push1`, `push2` and `orient_on` is high in any cycle.
- R11: After reset all outputs are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_seen | input | 1 | Entry proximity sensor |
| divert_seen | input | 1 | Side-conveyor proximity sensor |
| press_ok | input | 1 | Contact pressure at or above its set point |
| cls_valid | input | 1 | Classifier verdict valid |
| cls_code | input | 2 | 0 good, 1 second grade, 2 defective, 3 unknown |
| angle | input | ANG_W | Signed tilt of the part |
| ang_lo | input | ANG_W | Magnitude below which no correction is needed |
| ang_hi | input | ANG_W | Magnitude above which the line stops |
| dly_push1 | input | CNT_W | Cycles from verdict to first pusher |
| dly_push2 | input | CNT_W | Cycles from side sensor to second pusher |
| dly_orient | input | CNT_W | Cycles from verdict to orientation device |
| pulse_len | input | CNT_W | Pusher pulse width in cycles |
| orient_limit | input | CNT_W | Watchdog limit for the orientation device |
| err_clr | input | 1 | Clears the stop state |
| push1 | output | 1 | First pusher |
| push2 | output | 1 | Second pusher |
| orient_on | output | 1 | Orientation device drive |
| acq_strobe | output | 1 | Image capture strobe |
| err_stop | output | 1 | Sticky line-stop flag |

## Verification
A table of parts is run through the station. The good parts sit at zero tilt, just under and exactly at the lower limit, at the upper limit, one past it, and at the most negative angle. These separate the pass, correct and stop branches and show that the sign of the angle plays no part. Second-grade, defective and unknown parts, each followed by a side-sensor event, show that only the defective class fires the second pusher, and that the angle of an unknown part is ignored. The orientation cases cover pressure already present, pressure arriving after a few cycles, pressure arriving on the last allowed cycle, and pressure arriving one cycle too late; these pin down where the watchdog boundary lies. Zero delay and zero pulse settings confirm that 0 is treated as 1.

// File: rtl/sort_pkg.sv
`timescale 1ns/1ps
package sort_pkg;
  typedef enum logic [1:0] {
    CLS_A    = 2'd0,
    CLS_B    = 2'd1,
    CLS_BDEF = 2'd2,
    CLS_UNK  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    ZN_PASS = 2'd0,
    ZN_FIX  = 2'd1,
    ZN_BAD  = 2'd2
  } zone_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACQ, ST_CLASS, ST_WAIT1, ST_PUSH1, ST_SEEK2,
    ST_WAIT2, ST_PUSH2, ST_WAIT3, ST_ORIENT, ST_HALT
  } st_e;
endpackage

// File: rtl/edge_rise.sv
`timescale 1ns/1ps
// Rising-edge detector for a group of sensor lines.
module edge_rise #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= din;
  end

  assign rise = din & ~prev;
endmodule

// File: rtl/angle_window.sv
`timescale 1ns/1ps
// Sorts a signed angle into pass / correct / reject by its magnitude.
module angle_window
  import sort_pkg::*;
#(
  parameter int ANG_W = 12
) (
  input  logic signed [ANG_W-1:0] ang,
  input  logic        [ANG_W-1:0] lim_lo,
  input  logic        [ANG_W-1:0] lim_hi,
  output zone_e                   zone
);
  logic [ANG_W-1:0] raw;
  logic [ANG_W-1:0] mag;

  assign raw = ang;
  // The most negative value maps to 2**(ANG_W-1), which still fits unsigned.
  assign mag = raw[ANG_W-1] ? (~raw + {{(ANG_W-1){1'b0}}, 1'b1}) : raw;

  always_comb begin
    if (mag > lim_hi)      zone = ZN_BAD;   // reject test wins
    else if (mag < lim_lo) zone = ZN_PASS;
    else                   zone = ZN_FIX;
  end
endmodule

// File: rtl/cycle_timer.sv
`timescale 1ns/1ps
// Shared down-counter: a load of V makes a window of max(V,1) cycles.
module cycle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= (load_val == '0) ? '0 : load_val - W'(1);
    else if (cnt != '0)
      cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sort_station_ctrl.sv
`timescale 1ns/1ps
module sort_station_ctrl
  import sort_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ANG_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    entry_seen,
  input  logic                    divert_seen,
  input  logic                    press_ok,
  input  logic                    cls_valid,
  input  logic [1:0]              cls_code,
  input  logic signed [ANG_W-1:0] angle,
  input  logic [ANG_W-1:0]        ang_lo,
  input  logic [ANG_W-1:0]        ang_hi,
  input  logic [CNT_W-1:0]        dly_push1,
  input  logic [CNT_W-1:0]        dly_push2,
  input  logic [CNT_W-1:0]        dly_orient,
  input  logic [CNT_W-1:0]        pulse_len,
  input  logic [CNT_W-1:0]        orient_limit,
  input  logic                    err_clr,
  output logic                    push1,
  output logic                    push2,
  output logic                    orient_on,
  output logic                    acq_strobe,
  output logic                    err_stop
);
  localparam int SENS_N = 2;

  logic [SENS_N-1:0] rise_v;
  logic              entry_rise;
  logic              divert_rise;
  zone_e             zone;
  cls_e              cls;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_done;
  st_e               st, nxt;
  logic              def_q, def_n;

  edge_rise #(.N(SENS_N)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  ({divert_seen, entry_seen}),
    .rise (rise_v)
  );
  assign entry_rise  = rise_v[0];
  assign divert_rise = rise_v[1];

  angle_window #(.ANG_W(ANG_W)) u_win (
    .ang    (angle),
    .lim_lo (ang_lo),
    .lim_hi (ang_hi),
    .zone   (zone)
  );

  cycle_timer #(.W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  assign cls = cls_e'(cls_code);

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    def_n    = def_q;
    case (st)
      ST_IDLE:  if (entry_rise) nxt = ST_ACQ;
      ST_ACQ:   nxt = ST_CLASS;
      ST_CLASS: begin
        if (cls_valid) begin
          if (cls == CLS_A) begin
            case (zone)
              ZN_BAD:  nxt = ST_HALT;
              ZN_PASS: nxt = ST_IDLE;
              default: begin
                nxt      = ST_WAIT3;
                tmr_load = 1'b1;
                tmr_val  = dly_orient;
              end
            endcase
          end else begin
            nxt      = ST_WAIT1;
            tmr_load = 1'b1;
            tmr_val  = dly_push1;
            def_n    = (cls == CLS_BDEF);
          end
        end
      end
      ST_WAIT1: if (tmr_done) begin
        nxt = ST_PUSH1; tmr_load = 1'b1; tmr_val = pulse_len;
      end
      ST_PUSH1: if (tmr_done) nxt = def_q ? ST_SEEK2 : ST_IDLE;
      ST_SEEK2: if (divert_rise) begin
        nxt = ST_WAIT2; tmr_load = 1'b1; tmr_val = dly_push2;
      end
      ST_WAIT2: if (tmr_done) begin
        nxt = ST_PUSH2; tmr_load = 1'b1; tmr_val = pulse_len;
      end
      ST_PUSH2: if (tmr_done) nxt = ST_IDLE;
      ST_WAIT3: if (tmr_done) begin
        nxt = ST_ORIENT; tmr_load = 1'b1; tmr_val = orient_limit;
      end
      ST_ORIENT: begin
        if (press_ok)      nxt = ST_IDLE;
        else if (tmr_done) nxt = ST_HALT;
      end
      ST_HALT:  if (err_clr) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      def_q      <= 1'b0;
      push1      <= 1'b0;
      push2      <= 1'b0;
      orient_on  <= 1'b0;
      acq_strobe <= 1'b0;
      err_stop   <= 1'b0;
    end else begin
      st         <= nxt;
      def_q      <= def_n;
      push1      <= (nxt == ST_PUSH1);
      push2      <= (nxt == ST_PUSH2);
      orient_on  <= (nxt == ST_ORIENT);
      acq_strobe <= (nxt == ST_ACQ);
      err_stop   <= (nxt == ST_HALT);
    end
  end
endmodule

// File: rtl/sort_station_chk.sv
`timescale 1ns/1ps
module sort_station_chk (
  input logic clk,
  input logic rst,
  input logic err_clr,
  input logic press_ok,
  input logic push1,
  input logic push2,
  input logic orient_on,
  input logic acq_strobe,
  input logic err_stop
);
  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    acq_strobe |=> !acq_strobe);

  assert_one_actuator_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push1, push2, orient_on}));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    err_stop |-> !(push1 || push2 || orient_on || acq_strobe));

  assert_sticky_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (err_stop && !err_clr) |=> err_stop);

  assert_clear_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (err_stop && err_clr) |=> !err_stop);

  assert_press_release_R7: assert property (@(posedge clk) disable iff (rst)
    (orient_on && press_ok) |=> !orient_on);
endmodule

bind sort_station_ctrl sort_station_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .err_clr    (err_clr),
  .press_ok   (press_ok),
  .push1      (push1),
  .push2      (push2),
  .orient_on  (orient_on),
  .acq_strobe (acq_strobe),
  .err_stop   (err_stop)
);

// File: tb/sim_sort_station_ctrl.sv
`timescale 1ns/1ps
module sim_sort_station_ctrl;
  localparam int CNT_W = 8;
  localparam int ANG_W = 9;
  localparam int WIN   = 60;
  localparam int NV    = 12;
  localparam int LO    = 10;
  localparam int HI    = 60;
  localparam int OD    = 20;

  // {class[1:0], angle[8:0], press delay[7:0], side sensor event}
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 9'h000, 8'd0,  1'b0},  // good, level: pass
    {2'd0, 9'h009, 8'd0,  1'b0},  // good, 9 < LO: pass
    {2'd0, 9'h00A, 8'd2,  1'b0},  // good, = LO: correct
    {2'd0, 9'h1F6, 8'd4,  1'b0},  // good, -10: correct
    {2'd0, 9'h03C, 8'd0,  1'b0},  // good, = HI, press already high
    {2'd0, 9'h03D, 8'd0,  1'b0},  // good, 61: stop
    {2'd0, 9'h100, 8'd0,  1'b0},  // good, -256: stop
    {2'd0, 9'h01E, 8'd20, 1'b0},  // press on last allowed cycle
    {2'd0, 9'h1E2, 8'd21, 1'b0},  // press too late: watchdog
    {2'd1, 9'h000, 8'd0,  1'b1},  // second grade
    {2'd2, 9'h000, 8'd0,  1'b1},  // defective
    {2'd3, 9'h050, 8'd0,  1'b1}   // unknown, large angle
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic entry_seen = 1'b0, divert_seen = 1'b0, press_ok = 1'b0;
  logic cls_valid = 1'b0, err_clr = 1'b0;
  logic [1:0] cls_code = 2'd0;
  logic signed [ANG_W-1:0] angle = '0;
  logic [ANG_W-1:0] ang_lo = ANG_W'(LO), ang_hi = ANG_W'(HI);
  logic [CNT_W-1:0] dly_push1 = 8'd3, dly_push2 = 8'd4, dly_orient = 8'd2;
  logic [CNT_W-1:0] pulse_len = 8'd5, orient_limit = CNT_W'(OD);
  logic push1, push2, orient_on, acq_strobe, err_stop;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sort_station_ctrl #(.CNT_W(CNT_W), .ANG_W(ANG_W)) u0 (
    .clk(clk), .rst(rst), .entry_seen(entry_seen), .divert_seen(divert_seen),
    .press_ok(press_ok), .cls_valid(cls_valid), .cls_code(cls_code),
    .angle(angle), .ang_lo(ang_lo), .ang_hi(ang_hi), .dly_push1(dly_push1),
    .dly_push2(dly_push2), .dly_orient(dly_orient), .pulse_len(pulse_len),
    .orient_limit(orient_limit), .err_clr(err_clr), .push1(push1),
    .push2(push2), .orient_on(orient_on), .acq_strobe(acq_strobe),
    .err_stop(err_stop)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run_obj(input logic [1:0] c, input logic [8:0] a,
                         input int pd, input bit s2);
    int ai, mag, p1r, p1n, p2r, p2n, odr, odn, erf, acqn, multi, s2rel;
    bit divert, is_def, bad, pass, fix, wd, s2done, p1seen;
    ai = int'($signed(a));
    mag = (ai < 0) ? -ai : ai;
    divert = (c != 2'd0);
    is_def = (c == 2'd2);
    bad  = !divert && (mag > HI);
    pass = !divert && !bad && (mag < LO);
    fix  = !divert && !bad && !pass;
    wd   = fix && (pd > OD);
    p1r = -1; p1n = 0; p2r = -1; p2n = 0; odr = -1; odn = 0;
    erf = -1; acqn = 0; multi = 0; s2rel = -1; s2done = 0; p1seen = 0;

    @(negedge clk); entry_seen = 1'b1;
    @(negedge clk);
    chk("R1 strobe", int'(acq_strobe), 1);
    entry_seen = 1'b0; cls_valid = 1'b1; cls_code = c; angle = a;
    if (fix && pd == 0) press_ok = 1'b1;
    @(posedge clk); @(posedge clk);
    for (int r = 0; r < WIN; r++) begin
      @(negedge clk);
      if (r == 0) cls_valid = 1'b0;
      if (!pass && r == 1) entry_seen = 1'b1;
      if (r == 3) entry_seen = 1'b0;
      if (acq_strobe) acqn++;
      if (int'(push1) + int'(push2) + int'(orient_on) > 1) multi++;
      if (push1) begin
        if (p1r < 0) p1r = r;
        p1n++; p1seen = 1;
      end else if (p1seen && s2 && !s2done) begin
        divert_seen = 1'b1; s2rel = r + 1; s2done = 1;
      end
      if (s2done && r == s2rel + 1) divert_seen = 1'b0;
      if (push2) begin
        if (p2r < 0) p2r = r;
        p2n++;
      end
      if (orient_on) begin
        if (odr < 0) odr = r;
        odn++;
        if (pd > 0 && odn == pd) press_ok = 1'b1;
      end else if (odn > 0) press_ok = 1'b0;
      if (err_stop && erf < 0) erf = r;
    end
    press_ok = 1'b0; divert_seen = 1'b0;

    chk("R1 no strobe while busy", acqn, 0);
    chk("R10 one actuator", multi, 0);
    chk("R3 push1 width", p1n, divert ? eff(int'(pulse_len)) : 0);
    if (divert) chk("R2 push1 delay", p1r, eff(int'(dly_push1)));
    chk("R4 push2 width", p2n, (is_def && s2) ? eff(int'(pulse_len)) : 0);
    if (is_def && s2) chk("R4 push2 delay", p2r, s2rel + eff(int'(dly_push2)));
    chk("R7 orient cycles", odn,
        !fix ? 0 : (pd == 0 ? 1 : (pd > OD ? OD : pd)));
    if (fix) chk("R7 orient delay", odr, eff(int'(dly_orient)));
    if (pass) chk("R5 pass no stop", int'(err_stop), 0);
    chk("R6 R8 stop state", int'(err_stop), (bad || wd) ? 1 : 0);
    if (bad) chk("R6 stop cycle", erf, 0);
    if (wd)  chk("R8 watchdog cycle", erf, eff(int'(dly_orient)) + OD);
    if (bad || wd) begin
      @(negedge clk);
      chk("R9 stop held", int'(err_stop), 1);
      err_clr = 1'b1;
      @(negedge clk);
      chk("R9 clear", int'(err_stop), 0);
      err_clr = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset outputs",
        int'({push1, push2, orient_on, acq_strobe, err_stop}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 idle after reset",
        int'({push1, push2, orient_on, acq_strobe, err_stop}), 0);

    for (int i = 0; i < NV; i++)
      run_obj(VEC[i][19:18], VEC[i][17:9], int'(VEC[i][8:1]), VEC[i][0]);

    // R2 R3: zero delay and zero width act as one cycle
    dly_push1 = '0; pulse_len = '0;
    run_obj(2'd1, 9'h000, 0, 1'b0);
    dly_push1 = 8'd3; pulse_len = 8'd5;

    // R9: entry sensor ignored while stopped
    run_obj(2'd0, 9'h0C8, 0, 1'b0);
    @(negedge clk); chk("R9 stop again", int'(err_stop), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule